// File: doc/BRIEF.md
# Bus Clock Generator with Stretch and Stop

The block derives the external bus clock from the oscillator clock. With no stretch request pending, the bus clock spends one oscillator cycle low and one oscillator cycle high. The result is a square wave at half the oscillator rate.

A 2-bit mode input selects between four operating modes:

- In normal single-chip mode the pad driver starts disabled.
- In special single-chip and expanded modes the pad driver starts enabled.
- In peripheral mode the pad is never driven. The bus phase is then taken from an externally supplied clock.

Software can override the default enable by writing a new value. The new value is applied only at a low phase of the clock, so the pad never shows a runt pulse. A stop request freezes the clock low. After the stop request is released, one full low cycle passes before the clock rises again.

For accesses to slow external devices, a stretch request lengthens the high (data) phase by 0 to 3 extra oscillator cycles. The block provides a bus-phase indicator that tells downstream logic whether the current half-cycle carries the address (low) or the data (high). The reset input is asserted asynchronously, and its release is synchronized to the oscillator clock over two cycles.

Top module: `eclk_gen`

## Requirements
- R1: With no stretch and no stop, the internal phase alternates every oscillator cycle: each low cycle is followed by a high cycle.
- R2: While reset is asserted, `eclk_pad_o`, `eclk_pad_oe` and `bus_data_phase` are all 0.
- R3: In normal single-chip mode (`mode_sel`=2'b00), `eclk_pad_oe` stays 0 until software writes a 1.
- R4: In special single-chip mode (2'b01) and in expanded mode (2'b10), `eclk_pad_oe` becomes 1 at the first functional clock edge after reset is released. That edge is the third rising edge after `rst_n` goes high.
- R5: A software write (`sw_wr`=1, new value on `sw_en_val`) changes `eclk_pad_oe` only at an edge where the phase was low before the edge. A write made during a high phase therefore takes effect one phase later.
- R6: In peripheral mode (2'b11), the following hold:
  - `eclk_pad_oe` and `eclk_pad_o` stay 0, even after software writes a 1.
  - `bus_data_phase` follows `eclk_in` with a delay of two oscillator edges.
- R7: The phase is forced low at every edge where `stop_req` is 1, and `eclk_pad_o` is then 0.
- R8: At the first edge after `stop_req` falls, the phase stays low. It goes high at the edge after that.
- R9: `stretch_req` is sampled at the low-to-high edge, together with `stretch_xtra`=N. If `stretch_req` is 1, the following high phase lasts N+1 cycles, for N from 0 to 3. If `stretch_req` is 0, the high phase lasts 1 cycle whatever the value of `stretch_xtra`.
- R10: When the driver is enabled, `eclk_pad_o` equals the phase. When the driver is disabled, `eclk_pad_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 normal single-chip, 01 special single-chip, 10 expanded, 11 peripheral |
| sw_wr | input | 1 | Software write strobe for the output enable |
| sw_en_val | input | 1 | Enable value written with `sw_wr` |
| stop_req | input | 1 | Stop-mode request; halts the clock low |
| stretch_req | input | 1 | Stretch request for the next high phase |
| stretch_xtra | input | 2 | Number of extra high cycles when stretching |
| eclk_in | input | 1 | External bus clock used in peripheral mode |
| eclk_pad_o | output | 1 | Pad drive value of the bus clock |
| eclk_pad_oe | output | 1 | Pad output enable |
| bus_data_phase | output | 1 | 1 in the data half-cycle, 0 in the address half-cycle |

## Verification
Every result except the peripheral path is due at the edge directly after the stimulus:

- The phase, the pad drive and the stop response all update at that edge.
- An enable write needs one edge to be registered and then waits for a low phase. Its effect therefore lands one or two edges later, depending on the phase when it was written.
- After reset is released, the first functional edge is the third rising edge.
- In peripheral mode, `bus_data_phase` lags `eclk_in` by two edges.

The bench drives inputs 1 ns after a rising edge and samples 1 ns after each edge. It tracks phase alignment from the sampled `bus_data_phase`. Each check is placed at the exact edge count derived above.

// File: rtl/eclk_pkg.sv
`timescale 1ns/1ps
package eclk_pkg;
  typedef enum logic [1:0] {
    MODE_NSC = 2'b00,
    MODE_SSC = 2'b01,
    MODE_EXP = 2'b10,
    MODE_PER = 2'b11
  } eclk_mode_e;
endpackage

// File: rtl/eclk_sync.sv
`timescale 1ns/1ps
module eclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = d;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/eclk_phase.sv
`timescale 1ns/1ps
module eclk_phase #(
  parameter int XW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          stretch_req,
  input  logic [XW-1:0] stretch_xtra,
  output logic          phase_o
);
  localparam logic [XW-1:0] ONE = XW'(1);

  logic          ph_q, ph_d;
  logic [XW-1:0] left_q, left_d;

  always_comb begin
    ph_d   = ph_q;
    left_d = left_q;
    if (halt) begin
      ph_d   = 1'b0;
      left_d = '0;
    end else if (!ph_q) begin
      ph_d   = 1'b1;
      left_d = stretch_req ? stretch_xtra : '0;
    end else if (left_q != '0) begin
      left_d = left_q - ONE;
    end else begin
      ph_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      left_q <= '0;
    end else begin
      ph_q   <= ph_d;
      left_q <= left_d;
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/eclk_oe_ctl.sv
`timescale 1ns/1ps
module eclk_oe_ctl
  import eclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt,
  input  logic       low_phase,
  input  logic [1:0] mode_sel,
  input  logic       sw_wr,
  input  logic       sw_val,
  output logic       oe_o
);
  eclk_mode_e mode;
  logic sw_set_q, sw_set_d;
  logic sw_val_q, sw_val_d;
  logic en_q, en_d;
  logic dflt_en, want_en, apply_en;

  assign mode = eclk_mode_e'(mode_sel);

  always_comb begin
    dflt_en  = (mode == MODE_SSC) || (mode == MODE_EXP);
    want_en  = sw_set_q ? sw_val_q : dflt_en;
    apply_en = !halt && low_phase;
    sw_set_d = sw_set_q | sw_wr;
    sw_val_d = sw_wr ? sw_val : sw_val_q;
    en_d     = apply_en ? want_en : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_set_q <= 1'b0;
      sw_val_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      sw_set_q <= sw_set_d;
      sw_val_q <= sw_val_d;
      en_q     <= en_d;
    end
  end

  assign oe_o = en_q && (mode != MODE_PER);
endmodule

// File: rtl/eclk_gen.sv
`timescale 1ns/1ps
module eclk_gen
  import eclk_pkg::*;
#(
  parameter int XW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_osc,
  input  logic          rst_n,
  input  logic [1:0]    mode_sel,
  input  logic          sw_wr,
  input  logic          sw_en_val,
  input  logic          stop_req,
  input  logic          stretch_req,
  input  logic [XW-1:0] stretch_xtra,
  input  logic          eclk_in,
  output logic          eclk_pad_o,
  output logic          eclk_pad_oe,
  output logic          bus_data_phase
);
  logic rst_core_n;
  logic stop_q;
  logic halt;
  logic phase_int;
  logic ext_phase;

  eclk_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk_osc),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_core_n)
  );

  always_ff @(posedge clk_osc or negedge rst_core_n) begin
    if (!rst_core_n) stop_q <= 1'b0;
    else             stop_q <= stop_req;
  end

  assign halt = stop_req | stop_q;

  eclk_phase #(.XW(XW)) u_phase (
    .clk          (clk_osc),
    .rst_n        (rst_core_n),
    .halt         (halt),
    .stretch_req  (stretch_req),
    .stretch_xtra (stretch_xtra),
    .phase_o      (phase_int)
  );

  eclk_oe_ctl u_oe (
    .clk       (clk_osc),
    .rst_n     (rst_core_n),
    .halt      (halt),
    .low_phase (!phase_int),
    .mode_sel  (mode_sel),
    .sw_wr     (sw_wr),
    .sw_val    (sw_en_val),
    .oe_o      (eclk_pad_oe)
  );

  eclk_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk   (clk_osc),
    .rst_n (rst_core_n),
    .d     (eclk_in),
    .q     (ext_phase)
  );

  assign eclk_pad_o     = phase_int & eclk_pad_oe;
  assign bus_data_phase = (mode_sel == MODE_PER) ? ext_phase : phase_int;
endmodule

// File: rtl/eclk_gen_chk.sv
`timescale 1ns/1ps
module eclk_gen_chk #(
  parameter int XW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode_sel,
  input logic          stop_req,
  input logic          halt,
  input logic          ph,
  input logic          oe,
  input logic          pad,
  input logic          stretch_req,
  input logic [XW-1:0] stretch_xtra
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_half_rate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !ph) |=> ph);

  assert_oe_at_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_sel != 2'b11 && $stable(mode_sel) && !$stable(oe)) |-> !$past(ph));

  assert_periph_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |-> (!oe && !pad));

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!ph && !pad));

  assert_resume_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(stop_req)) |=> !ph);

  assert_stretch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !ph && stretch_req && stretch_xtra != '0) |=> ph ##1 (ph || $past(halt)));

  assert_pad_needs_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(pad)) |-> oe);
endmodule

bind eclk_gen eclk_gen_chk #(.XW(XW)) u_chk (
  .clk          (clk_osc),
  .rst_n        (rst_core_n),
  .mode_sel     (mode_sel),
  .stop_req     (stop_req),
  .halt         (halt),
  .ph           (phase_int),
  .oe           (eclk_pad_oe),
  .pad          (eclk_pad_o),
  .stretch_req  (stretch_req),
  .stretch_xtra (stretch_xtra)
);

// File: tb/eclk_gen_bench.sv
`timescale 1ns/1ps
module eclk_gen_bench;
  logic       clk_osc = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       sw_wr = 1'b0;
  logic       sw_en_val = 1'b0;
  logic       stop_req = 1'b0;
  logic       stretch_req = 1'b0;
  logic [1:0] stretch_xtra = 2'b00;
  logic       eclk_in = 1'b0;
  logic       eclk_pad_o, eclk_pad_oe, bus_data_phase;

  int n_chk = 0;
  int n_fail = 0;

  // {stretch_req, stretch_xtra, expected high length}
  localparam logic [5:0] STRETCH_VEC [6] = '{
    {1'b1, 2'd0, 3'd1},
    {1'b1, 2'd1, 3'd2},
    {1'b1, 2'd2, 3'd3},
    {1'b1, 2'd3, 3'd4},
    {1'b0, 2'd3, 3'd1},
    {1'b1, 2'd1, 3'd2}
  };

  eclk_gen u_eclk_gen (
    .clk_osc        (clk_osc),
    .rst_n          (rst_n),
    .mode_sel       (mode_sel),
    .sw_wr          (sw_wr),
    .sw_en_val      (sw_en_val),
    .stop_req       (stop_req),
    .stretch_req    (stretch_req),
    .stretch_xtra   (stretch_xtra),
    .eclk_in        (eclk_in),
    .eclk_pad_o     (eclk_pad_o),
    .eclk_pad_oe    (eclk_pad_oe),
    .bus_data_phase (bus_data_phase)
  );

  always #2.5 clk_osc = ~clk_osc;

  task automatic step();
    @(posedge clk_osc);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Leaves the bench just after the second edge following release.
  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0;
    mode_sel = m;
    sw_wr = 1'b0;
    sw_en_val = 1'b0;
    stop_req = 1'b0;
    stretch_req = 1'b0;
    stretch_xtra = 2'b00;
    eclk_in = 1'b0;
    step();
    step();
    chk("R2 pad in reset", eclk_pad_o, 1'b0);
    chk("R2 oe in reset", eclk_pad_oe, 1'b0);
    chk("R2 phase in reset", bus_data_phase, 1'b0);
    rst_n = 1'b1;
    step();
    step();
    chk("R4 oe before first functional edge", eclk_pad_oe, 1'b0);
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int len;

    // Special single-chip mode: default enabled
    do_reset(2'b01);
    step();
    chk("R4 special oe", eclk_pad_oe, 1'b1);
    chk("R1 first high", bus_data_phase, 1'b1);
    chk("R10 pad high", eclk_pad_o, 1'b1);
    step();
    chk("R1 low", bus_data_phase, 1'b0);
    chk("R10 pad low", eclk_pad_o, 1'b0);
    step();
    chk("R1 high again", bus_data_phase, 1'b1);
    chk("R10 pad follows", eclk_pad_o, 1'b1);
    sw_wr = 1'b1;
    sw_en_val = 1'b0;
    step();
    sw_wr = 1'b0;
    chk("R5 disable deferred", eclk_pad_oe, 1'b1);
    chk("R1 low after write", bus_data_phase, 1'b0);
    step();
    chk("R5 disable applied", eclk_pad_oe, 1'b0);
    chk("R10 pad off when disabled", eclk_pad_o, 1'b0);

    // Normal single-chip mode: default disabled
    do_reset(2'b00);
    step();
    chk("R3 normal oe", eclk_pad_oe, 1'b0);
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R3 normal oe held", eclk_pad_oe, 1'b0);
    end
    chk("R1 alignment", bus_data_phase, 1'b1);
    sw_wr = 1'b1;
    sw_en_val = 1'b1;
    step();
    sw_wr = 1'b0;
    chk("R5 enable deferred", eclk_pad_oe, 1'b0);
    step();
    chk("R5 enable applied", eclk_pad_oe, 1'b1);
    chk("R10 pad after enable", eclk_pad_o, 1'b1);

    // Expanded mode: stretch table
    do_reset(2'b10);
    step();
    chk("R4 expanded oe", eclk_pad_oe, 1'b1);
    for (int i = 0; i < 6; i++) begin
      if (bus_data_phase) step();
      stretch_req = STRETCH_VEC[i][5];
      stretch_xtra = STRETCH_VEC[i][4:3];
      step();
      stretch_req = 1'b0;
      stretch_xtra = 2'b00;
      len = 0;
      while (bus_data_phase && len < 8) begin
        len++;
        chk("R10 pad during stretch", eclk_pad_o, 1'b1);
        step();
      end
      chk_int("R9 high length", len, int'(STRETCH_VEC[i][2:0]));
    end

    // Stop and resume
    if (!bus_data_phase) step();
    stop_req = 1'b1;
    step();
    chk("R7 stopped low", bus_data_phase, 1'b0);
    chk("R7 pad low", eclk_pad_o, 1'b0);
    step();
    chk("R7 still low", bus_data_phase, 1'b0);
    step();
    chk("R7 still low 2", bus_data_phase, 1'b0);
    stop_req = 1'b0;
    step();
    chk("R8 first cycle low", bus_data_phase, 1'b0);
    step();
    chk("R8 then high", bus_data_phase, 1'b1);
    chk("R8 oe kept", eclk_pad_oe, 1'b1);

    // Peripheral mode
    do_reset(2'b11);
    step();
    chk("R6 periph oe", eclk_pad_oe, 1'b0);
    sw_wr = 1'b1;
    sw_en_val = 1'b1;
    step();
    sw_wr = 1'b0;
    step();
    step();
    chk("R6 oe after write", eclk_pad_oe, 1'b0);
    chk("R6 pad undriven", eclk_pad_o, 1'b0);
    chk("R6 ext phase low", bus_data_phase, 1'b0);
    eclk_in = 1'b1;
    step();
    chk("R6 ext lag 1", bus_data_phase, 1'b0);
    step();
    chk("R6 ext rise", bus_data_phase, 1'b1);
    eclk_in = 1'b0;
    step();
    chk("R6 ext lag fall", bus_data_phase, 1'b1);
    step();
    chk("R6 ext fall", bus_data_phase, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule